// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a 32-bit status register that records why a processor power domain was last reset. Five cause inputs (global cold, global warm, wake-up of this domain, wake-up of the core domain from OFF to ON, and emulation) are sampled and accumulated for as long as the domain reset input is asserted. When that reset is released, every accumulated cause is merged into the register on the next clock edge. Bits already in the register stay set until software clears them.

Software reaches the register over a single-cycle bus with select, read strobe, write strobe, 32-bit write data and 32-bit read data. Writing 1 to a cause bit clears it, and writing 0 leaves it alone. Reads are combinational. The register is initialised only by the asynchronous power-on (cold) reset, which leaves the cold-reset bit set. Warm, wake-up and emulation resets of the domain never erase earlier history.

Top module: `rst_cause_log`

## Requirements
- R1: Each cause has a fixed bit position. Bit 0 is global cold reset, bit 1 is global warm reset, bit 2 is a wake-up of this domain, bit 3 is a core-domain OFF-to-ON wake-up, and bit 11 is emulation reset.
- R2: Bits 31:12 and 10:4 always read as 0, and writes to them have no effect.
- R3: A cause bit becomes set only on the clock edge at which the domain reset is first sampled low after being sampled high. It never becomes set while the domain reset is sampled high.
- R4: A selected write clears every cause bit whose write-data bit is 1. Cause bits whose write-data bit is 0 keep their value.
- R5: While the power-on reset is low, and right after it is released, the register reads 0x00000001.
- R6: A cause counts if it is high on any clock edge at which the domain reset is sampled high. All causes counted during one reset are set together on release.
- R7: A domain reset assertion and release does not clear any bit that is already set. Only the power-on reset reinitialises the contents.
- R8: If a write-1 clear and a release-time set hit the same bit in the same cycle, the bit ends up set.
- R9: When the register is selected, rdata shows the current value combinationally. When it is not selected, rdata is 0, and writes without select are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dom_rst | input | 1 | Domain reset, active high, synchronous to clk |
| cause_cold | input | 1 | Global cold reset cause |
| cause_warm | input | 1 | Global warm reset cause |
| cause_own_wake | input | 1 | Own-domain wake-up cause |
| cause_core_wake | input | 1 | Core-domain wake-up cause |
| cause_emu | input | 1 | Emulation reset cause |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |

## Verification
Two events can land in the same cycle: a software write-1 clear, and the hardware set that happens when the domain reset is released. The bench triggers this collision both in directed cases and at random, by issuing a write with all-ones or random data on the exact cycle the domain reset drops. It then reads the register on the next cycle and checks that every bit set by the release is still 1. Bits that were not set by the release must still follow the write.

// File: rtl/rst_cause_log.sv
module rst_cause_log #(
  parameter int DW        = 32,
  parameter int COLD_BIT  = 0,
  parameter int WARM_BIT  = 1,
  parameter int OWN_BIT   = 2,
  parameter int CORE_BIT  = 3,
  parameter int EMU_BIT   = 11
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          dom_rst,
  input  logic          cause_cold,
  input  logic          cause_warm,
  input  logic          cause_own_wake,
  input  logic          cause_core_wake,
  input  logic          cause_emu,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] MASK     = (ONE << COLD_BIT) | (ONE << WARM_BIT) | (ONE << OWN_BIT)
                                     | (ONE << CORE_BIT) | (ONE << EMU_BIT);
  localparam logic [DW-1:0] POR_VAL  = ONE << COLD_BIT;

  logic [DW-1:0] stat, held, cause_vec, clr_vec, set_vec;
  logic          dom_q, release_edge;

  always_comb begin
    cause_vec           = '0;
    cause_vec[COLD_BIT] = cause_cold;
    cause_vec[WARM_BIT] = cause_warm;
    cause_vec[OWN_BIT]  = cause_own_wake;
    cause_vec[CORE_BIT] = cause_core_wake;
    cause_vec[EMU_BIT]  = cause_emu;
  end

  assign release_edge = dom_q & ~dom_rst;
  assign clr_vec      = (sel & wr) ? (wdata & MASK) : '0;
  assign set_vec      = release_edge ? held : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dom_q <= 1'b0;
      held  <= '0;
      stat  <= POR_VAL;
    end else begin
      dom_q <= dom_rst;
      held  <= dom_rst ? (held | cause_vec) : '0;
      stat  <= (stat & ~clr_vec) | set_vec;
    end
  end

  assign rdata = sel ? (stat & MASK) : '0;

  logic unused_rd;
  assign unused_rd = rd;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    (rdata & ~MASK) == '0);

  a_r9_unselected_zero: assert property (@(posedge clk) disable iff (!por_n)
    !sel |-> rdata == '0);

  a_r3_no_set_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    dom_rst |=> (stat & ~$past(stat)) == '0);

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!por_n)
    (sel && wr && !release_edge) |=> (stat & $past(wdata & MASK)) == '0);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    release_edge |=> (stat & $past(held)) == $past(held));

  a_r7_no_loss_without_write: assert property (@(posedge clk) disable iff (!por_n)
    !(sel && wr) |=> (stat & $past(stat)) == $past(stat));

endmodule

// File: tb/sim_rst_cause_log.sv
module sim_rst_cause_log;
  localparam logic [31:0] MASK = 32'h0000_080F;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        dom_rst = 1'b0;
  logic        c_cold = 0, c_warm = 0, c_own = 0, c_core = 0, c_emu = 0;
  logic        sel = 0, rd = 0, wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_stat, m_held;
  logic        m_domq;

  always #2 clk = ~clk;

  rst_cause_log u0 (
    .clk(clk), .por_n(por_n), .dom_rst(dom_rst),
    .cause_cold(c_cold), .cause_warm(c_warm), .cause_own_wake(c_own),
    .cause_core_wake(c_core), .cause_emu(c_emu),
    .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] cvec(logic [4:0] c);
    return {20'b0, c[4], 7'b0, c[3], c[2], c[1], c[0]};
  endfunction

  function automatic logic [31:0] next_stat(logic [31:0] s, logic [31:0] h, logic domq,
                                            logic dom, logic w, logic [31:0] d);
    logic [31:0] clr, set;
    clr = w ? (d & MASK) : '0;
    set = (domq && !dom) ? h : '0;
    return (s & ~clr) | set;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic dom, logic [4:0] c, logic w, logic [31:0] d);
    dom_rst = dom;
    {c_emu, c_core, c_own, c_warm, c_cold} = c;
    sel = w; wr = w; rd = 0; wdata = d;
    @(posedge clk);
    m_stat = next_stat(m_stat, m_held, m_domq, dom, w, d);
    m_held = dom ? (m_held | cvec(c)) : '0;
    m_domq = dom;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic read_chk(string req);
    sel = 1; rd = 1; wr = 0;
    #1 chk(req, rdata, m_stat);
    sel = 0; rd = 0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 0; dom_rst = 0;
    m_stat = 32'h1; m_held = '0; m_domq = 0;
    #1 sel = 1;
    #0 chk("R5 during power-on reset", rdata, 32'h1);
    sel = 0;
    @(negedge clk) por_n = 1;
  endtask

  task automatic dom_reset(logic [4:0] c, int len);
    for (int i = 0; i < len; i++) step(1'b1, c, 1'b0, '0);
  endtask

  initial begin
    m_stat = 32'h1; m_held = '0; m_domq = 0;
    void'($urandom(32'd4711));
    do_por();
    read_chk("R5 reset value");
    sel = 0;
    #1 chk("R9 unselected read", rdata, 32'h0);

    dom_reset(5'b00010, 3);
    read_chk("R3 no set while reset held");
    step(1'b0, 5'b0, 1'b0, '0);
    read_chk("R1 warm bit 1 set on release");
    chk("R1 warm value", m_stat, 32'h3);

    dom_reset(5'b00100, 1); dom_reset(5'b01000, 1); dom_reset(5'b10000, 1);
    step(1'b0, 5'b0, 1'b0, '0);
    read_chk("R6 multiple causes merged");
    chk("R1 bit map own/core/emu", m_stat, 32'h80F);

    step(1'b0, 5'b0, 1'b1, 32'h0000_0002);
    read_chk("R4 clear warm only");
    step(1'b0, 5'b0, 1'b1, 32'h0000_0000);
    read_chk("R4 write zero no change");

    step(1'b0, 5'b0, 1'b1, 32'hFFFF_F7F0);
    read_chk("R2 reserved writes ignored");
    sel = 1; #1 chk("R2 reserved bits zero", rdata & ~MASK, 32'h0); sel = 0;

    wdata = 32'hFFFF_FFFF; wr = 1; sel = 0;
    @(posedge clk); @(negedge clk); wr = 0;
    read_chk("R9 write without select ignored");

    dom_reset(5'b00010, 2);
    step(1'b0, 5'b0, 1'b0, '0);
    read_chk("R7 old bits survive warm reset");

    dom_reset(5'b10001, 2);
    step(1'b0, 5'b0, 1'b1, 32'hFFFF_FFFF);
    read_chk("R8 set wins over clear");
    chk("R8 value", m_stat, 32'h801);

    dom_reset(5'b00100, 1);
    step(1'b0, 5'b0, 1'b0, '0);
    do_por();
    read_chk("R5 cold reset reinit");

    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] < 4) dom_reset(5'(r[8:4]), 1 + int'(r[10:9]));
      step(1'b0, 5'(r[15:11]), r[16], r[16] ? ($urandom & (r[17] ? 32'hFFFF_FFFF : $urandom)) : '0);
      read_chk("R8/R4/R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule